// File: doc/BRIEF.md
# Supervisor-Aware Program Counter Unit

This block keeps the 32-bit instruction address of a small RISC core and works out where execution goes next. Each step, a 3-bit select picks the next address from five sources: the sequential address, a branch target formed from the 16-bit literal of the current instruction, a jump target taken from a register read port, and two fixed vectors for illegal-opcode traps and interrupts. Any other select value keeps the present address. The register only moves on clock edges where the step strobe is high, so the core can run far slower than the clock.

The top bit of the address is the privilege flag. Supervisor mode is on while it is set. The unit guards this bit. The address arithmetic works on the lower 31 bits and never carries into the flag. A jump may clear the flag but can never set it. Only reset and the two fixed vectors can set it. The sequential address and the branch target also leave the unit as outputs, for register write-back and for address arithmetic elsewhere in the core.

Top module: `priv_pc_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the address register loads 0x80000000. This happens whatever `step_en` and `nxt_sel` are.
- R2: With `rst` low and `step_en` low at a rising edge, `pc_q` keeps its value.
- R3: `pc_plus4` is `pc_q` with 4 added to bits 30:0, wrapping inside those 31 bits. Bit 31 is copied from `pc_q[31]`. Select code 000 loads this value.
- R4: `br_target` is `pc_plus4` plus the sign-extended `lit16` shifted left by two. The sum's bit 31 is replaced by `pc_q[31]` and its low two bits are forced to 00. Select code 001 loads this value.
- R5: Select code 010 loads `jmp_addr` with bits 1:0 forced to 00. The new bit 31 is `jmp_addr[31] AND pc_q[31]`.
- R6: Select code 011 loads the illegal-opcode vector 0x80000004.
- R7: Select code 100 loads the interrupt vector 0x80000008.
- R8: Select codes 101, 110 and 111 leave `pc_q` unchanged when a step happens.
- R9: `pc_q[31]` goes from 0 to 1 only through reset or select codes 011 and 100.
- R10: `pc_q[1:0]` is always 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high. Loads the boot vector |
| step_en | input | 1 | Advance strobe. The address register moves only when this is high |
| nxt_sel | input | 3 | Next-address select: 000 seq, 001 branch, 010 jump, 011 trap, 100 interrupt |
| jmp_addr | input | 32 | Jump target word from a register read port |
| lit16 | input | 16 | Signed literal field of the current instruction (word offset) |
| pc_q | output | 32 | Current instruction address, bit 31 = supervisor flag |
| pc_plus4 | output | 32 | Sequential address with the flag preserved |
| br_target | output | 32 | Branch target with the flag preserved |

## Verification
`pc_q` changes one rising edge after the step strobe, the select and the operands are applied. `pc_plus4` and `br_target` are combinational. They follow `pc_q` and `lit16` in the same cycle. The bench drives inputs just after a falling edge and lets the model take its step at the next rising edge. It compares all three outputs at the following falling edge. Each compare therefore sees the register exactly one edge after its stimulus, and the combinational outputs as they settle from that new register value and the current literal.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

  typedef enum logic [2:0] {
    SEL_SEQ  = 3'b000,
    SEL_BR   = 3'b001,
    SEL_JMP  = 3'b010,
    SEL_TRAP = 3'b011,
    SEL_IRQ  = 3'b100
  } nxt_sel_e;

  localparam logic [31:0] BOOT_VEC = 32'h8000_0000;
  localparam logic [31:0] TRAP_VEC = 32'h8000_0004;
  localparam logic [31:0] IRQ_VEC  = 32'h8000_0008;

endpackage

// File: rtl/pcu_seq_math.sv
module pcu_seq_math #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic [AW-1:0] pc_cur,
  input  logic [LW-1:0] lit,
  output logic [AW-1:0] seq_addr,
  output logic [AW-1:0] br_addr
);
  localparam int EXTW = AW - LW - 2;

  function automatic logic [AW-1:0] f_seq(input logic [AW-1:0] p);
    logic [AW-2:0] low;
    low = p[AW-2:0] + (AW-1)'(4);
    return {p[AW-1], low[AW-2:2], 2'b00};
  endfunction

  function automatic logic [AW-1:0] f_branch(input logic [AW-1:0] p4,
                                             input logic [LW-1:0] l,
                                             input logic          flag);
    logic [AW-1:0] offs;
    logic [AW-1:0] sum;
    offs = {{EXTW{l[LW-1]}}, l, 2'b00};
    sum  = p4 + offs;
    return {flag, sum[AW-2:2], 2'b00};
  endfunction

  always_comb begin
    seq_addr = f_seq(pc_cur);
    br_addr  = f_branch(seq_addr, lit, pc_cur[AW-1]);
  end
endmodule

// File: rtl/pcu_jump_guard.sv
module pcu_jump_guard #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] jt_raw,
  input  logic          flag_now,
  output logic [AW-1:0] jt_safe
);
  function automatic logic [AW-1:0] f_guard(input logic [AW-1:0] j, input logic f);
    return {j[AW-1] & f, j[AW-2:2], 2'b00};
  endfunction

  always_comb jt_safe = f_guard(jt_raw, flag_now);
endmodule

// File: rtl/pcu_next_mux.sv
module pcu_next_mux #(
  parameter int AW = 32
) (
  input  logic [2:0]    sel,
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] seq_addr,
  input  logic [AW-1:0] br_addr,
  input  logic [AW-1:0] jt_safe,
  input  logic [AW-1:0] trap_vec,
  input  logic [AW-1:0] irq_vec,
  output logic [AW-1:0] nxt
);
  import pcu_pkg::*;

  always_comb begin
    unique case (sel)
      SEL_SEQ:  nxt = seq_addr;
      SEL_BR:   nxt = br_addr;
      SEL_JMP:  nxt = jt_safe;
      SEL_TRAP: nxt = trap_vec;
      SEL_IRQ:  nxt = irq_vec;
      default:  nxt = cur;
    endcase
  end
endmodule

// File: rtl/priv_pc_unit.sv
module priv_pc_unit #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step_en,
  input  logic [2:0]    nxt_sel,
  input  logic [AW-1:0] jmp_addr,
  input  logic [LW-1:0] lit16,
  output logic [AW-1:0] pc_q,
  output logic [AW-1:0] pc_plus4,
  output logic [AW-1:0] br_target
);
  import pcu_pkg::*;

  localparam logic [AW-1:0] BOOT_A = AW'(BOOT_VEC);
  localparam logic [AW-1:0] TRAP_A = AW'(TRAP_VEC);
  localparam logic [AW-1:0] IRQ_A  = AW'(IRQ_VEC);

  logic [AW-1:0] pc_r;
  logic [AW-1:0] seq_w;
  logic [AW-1:0] br_w;
  logic [AW-1:0] jt_w;
  logic [AW-1:0] nxt_w;
  logic          flag_w;

  assign flag_w = pc_r[AW-1];

  pcu_seq_math #(.AW(AW), .LW(LW)) u_math (
    .pc_cur  (pc_r),
    .lit     (lit16),
    .seq_addr(seq_w),
    .br_addr (br_w)
  );

  pcu_jump_guard #(.AW(AW)) u_jg (
    .jt_raw  (jmp_addr),
    .flag_now(flag_w),
    .jt_safe (jt_w)
  );

  pcu_next_mux #(.AW(AW)) u_mux (
    .sel     (nxt_sel),
    .cur     (pc_r),
    .seq_addr(seq_w),
    .br_addr (br_w),
    .jt_safe (jt_w),
    .trap_vec(TRAP_A),
    .irq_vec (IRQ_A),
    .nxt     (nxt_w)
  );

  always_ff @(posedge clk) begin
    if (rst)          pc_r <= BOOT_A;
    else if (step_en) pc_r <= nxt_w;
  end

  assign pc_q      = pc_r;
  assign pc_plus4  = seq_w;
  assign br_target = br_w;

  logic past_ok;
  always_ff @(posedge clk) past_ok <= 1'b1;

  AST_BOOT_VECTOR: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(rst)) |-> (pc_q == BOOT_A)); // R1

  AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(rst) && !$past(step_en)) |-> $stable(pc_q)); // R2

  AST_SEQ_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (pc_plus4[AW-1] == pc_q[AW-1])); // R3

  AST_BR_FLAG_KEPT: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (br_target[AW-1] == pc_q[AW-1])); // R4

  AST_JMP_NO_RAISE: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(rst) && $past(step_en) && ($past(nxt_sel) == 3'b010)
     && !$past(pc_q[AW-1])) |-> !pc_q[AW-1]); // R5

  AST_FLAG_RISE_SRC: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(rst) && $rose(pc_q[AW-1]))
    |-> ($past(nxt_sel) == 3'b011 || $past(nxt_sel) == 3'b100)); // R9

  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (pc_q[1:0] == 2'b00)); // R10
endmodule

// File: tb/sim_priv_pc_unit.sv
module sim_priv_pc_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        step_en;
  logic [2:0]  nxt_sel;
  logic [31:0] jmp_addr;
  logic [15:0] lit16;
  logic [31:0] pc_q, pc_plus4, br_target;

  int n_vec = 0;
  int n_bad = 0;
  logic [31:0] m_pc;
  bit done = 0;

  always #2.5 clk = ~clk;

  priv_pc_unit u0 (
    .clk(clk), .rst(rst), .step_en(step_en), .nxt_sel(nxt_sel),
    .jmp_addr(jmp_addr), .lit16(lit16),
    .pc_q(pc_q), .pc_plus4(pc_plus4), .br_target(br_target)
  );

  function automatic logic [31:0] m_seq(input logic [31:0] p);
    longint unsigned v;
    v = ((longint'(p) & 64'h7FFF_FFFF) + 4) % 64'h8000_0000;
    return (32'(v) & 32'h7FFF_FFFC) | (p & 32'h8000_0000);
  endfunction

  function automatic logic [31:0] m_br(input logic [31:0] p, input logic [15:0] l);
    longint signed off;
    longint signed s;
    off = longint'($signed(l)) * 4;
    s = longint'(m_seq(p)) + off;
    return (32'(s) & 32'h7FFF_FFFC) | (p & 32'h8000_0000);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // one step: drive, clock, update model, compare at falling edge
  task automatic cyc(input bit r, input bit en, input logic [2:0] s,
                     input logic [31:0] j, input logic [15:0] l, input string req);
    logic [31:0] nx;
    rst = r; step_en = en; nxt_sel = s; jmp_addr = j; lit16 = l;
    if (r) nx = 32'h8000_0000;
    else if (!en) nx = m_pc;
    else case (s)
      3'd0: nx = m_seq(m_pc);
      3'd1: nx = m_br(m_pc, l);
      3'd2: nx = {j[31] & m_pc[31], j[30:2], 2'b00};
      3'd3: nx = 32'h8000_0004;
      3'd4: nx = 32'h8000_0008;
      default: nx = m_pc;
    endcase
    @(posedge clk);
    m_pc = nx;
    @(negedge clk);
    chk({req, " pc"}, pc_q, m_pc);
    chk("R3 pc_plus4", pc_plus4, m_seq(m_pc));
    chk("R4 br_target", br_target, m_br(m_pc, l));
    if (pc_q[1:0] !== 2'b00) chk("R10 align", {30'd0, pc_q[1:0]}, 32'd0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    m_pc = 32'h0;
    rst = 1; step_en = 0; nxt_sel = 3'd0; jmp_addr = 32'h0; lit16 = 16'h0;
    @(negedge clk);
    // R1 reset state, with step and a jump asserted to show priority
    cyc(1, 1, 3'd2, 32'h0000_1234, 16'h0, "R1");
    cyc(1, 0, 3'd0, 32'h0, 16'h0, "R1");
    // R3 sequential in supervisor mode
    cyc(0, 1, 3'd0, 32'h0, 16'h0, "R3");
    cyc(0, 1, 3'd0, 32'h0, 16'h0, "R3");
    // R2 hold
    cyc(0, 0, 3'd0, 32'h0, 16'h0, "R2");
    cyc(0, 0, 3'd3, 32'h0, 16'h0, "R2");
    // R4 branch forward and backward
    cyc(0, 1, 3'd1, 32'h0, 16'h0010, "R4");
    cyc(0, 1, 3'd1, 32'h0, 16'hFFFB, "R4");
    // R5 jump keeps flag when both set, low bits forced
    cyc(0, 1, 3'd2, 32'h8000_0123, 16'h0, "R5");
    // R5 jump clears flag
    cyc(0, 1, 3'd2, 32'h0000_0040, 16'h0, "R5");
    // R5 R9 jump cannot set flag from user mode
    cyc(0, 1, 3'd2, 32'hFFFF_FFFF, 16'h0, "R5 R9");
    // R8 unused codes hold
    cyc(0, 1, 3'd5, 32'h0, 16'h0, "R8");
    cyc(0, 1, 3'd6, 32'h0, 16'h0, "R8");
    cyc(0, 1, 3'd7, 32'h0, 16'h0, "R8");
    // R3 wrap inside 31 bits, user mode at top of user space
    cyc(0, 1, 3'd2, 32'h7FFF_FFFC, 16'h0, "R5");
    cyc(0, 1, 3'd0, 32'h0, 16'h0, "R3 wrap");
    // R4 branch wrapping below zero stays in user space
    cyc(0, 1, 3'd1, 32'h0, 16'h8000, "R4 wrap");
    // R6 trap sets flag
    cyc(0, 1, 3'd3, 32'h0, 16'h0, "R6 R9");
    cyc(0, 1, 3'd2, 32'h0000_0100, 16'h0, "R5");
    // R7 interrupt sets flag
    cyc(0, 1, 3'd4, 32'h0, 16'h0, "R7 R9");
    // R3 supervisor wrap keeps flag
    cyc(0, 1, 3'd2, 32'hFFFF_FFFC, 16'h0, "R5");
    cyc(0, 1, 3'd0, 32'h0, 16'h0, "R3 wrap");
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] rv;
      rv = $urandom;
      cyc((rv[3:0] == 4'd0), (rv[6:4] != 3'd0), 3'(rv[9:7]),
          32'($urandom), 16'($urandom), "R9 mix");
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule